// File: doc/BRIEF.md
# FIFO Watermark DMA and Transmit-Start Controller

This block decides, from how full the transmit and receive byte FIFOs of a network controller are, when the bus-master engine should move data and when the MAC should begin putting a frame on the wire. A 2-bit watermark code selects a byte amount of 8, 16, 24 or 32. Receive bursts are requested when that many bytes are waiting or when a complete frame end sits in the receive FIFO. Transmit bursts are requested when that many byte locations are free.

Frame transmission is started by a single-cycle strobe. In the normal mode the strobe waits until the transmit FIFO is nearly full: only the watermark amount of space is left. In early-start mode the strobe fires as soon as the watermark amount of bytes is present. A frame whose last byte is already queued starts at once, whatever the count. Early start can drain the FIFO before the frame is complete, so the block flags transmit underrun.

The configuration inputs are taken into a shadow register only while no frame is being sent, so a frame in flight always runs with one consistent set of thresholds.

Top module: `fifo_watermark_ctrl`

## Requirements
- R1: Watermark code c (2 bits) selects a watermark of (c+1)*8 bytes: 00=8, 01=16, 10=24, 11=32.
- R2: `rx_dma_req` is high in the same cycle that `rx_level` is at least the active watermark.
- R3: `rx_dma_req` is high whenever `rx_eof_present` is high, even when `rx_level` is below the watermark.
- R4: `tx_dma_req` is high exactly when 128 minus `tx_level` is at least the active watermark, so it is low at `tx_level`=128.
- R5: With early-start clear, while idle `tx_start` is high in the same cycle that `tx_level` is at least 128 minus the watermark (120, 112, 104, 96 for codes 00..11).
- R6: With early-start set, while idle `tx_start` is high in the same cycle that `tx_level` is at least the watermark (8, 16, 24, 32).
- R7: While idle, `tx_eof_present` high makes `tx_start` high even when `tx_level` is below the start threshold.
- R8: `tx_start` is a one-cycle pulse; `tx_active` is high from the cycle after it until the cycle after `tx_frame_done`, and no further `tx_start` occurs in between; after that the start re-arms.
- R9: While `tx_active`, if `tx_level` becomes 0 with neither `tx_eof_present` high now nor seen earlier in the frame, `tx_underrun` is high for exactly one cycle, in the cycle after the FIFO went empty.
- R10: Once `tx_eof_present` has been seen during the frame, an empty transmit FIFO does not raise `tx_underrun`.
- R11: `cfg_wm_code` and `cfg_early_start` are captured at a clock edge only when `tx_active` is low and act from the next cycle; changes during a frame have no effect until after it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wm_code | input | 2 | Watermark code |
| cfg_early_start | input | 1 | Early-start mode select |
| tx_level | input | 8 | Bytes held in the transmit FIFO (0..128) |
| tx_eof_present | input | 1 | Last byte of the current transmit frame is in the FIFO |
| tx_frame_done | input | 1 | MAC has finished sending the current frame |
| rx_level | input | 8 | Bytes held in the receive FIFO (0..128) |
| rx_eof_present | input | 1 | A frame end is held in the receive FIFO |
| rx_dma_req | output | 1 | Receive DMA burst request |
| tx_dma_req | output | 1 | Transmit DMA burst request |
| tx_start | output | 1 | One-cycle frame transmission start strobe |
| tx_active | output | 1 | A frame is being transmitted |
| tx_underrun | output | 1 | One-cycle transmit underrun flag |

## Verification
The bench builds the block with its default parameters: a 128-byte FIFO depth and an 8-byte watermark step, giving 8-bit level inputs. That brings every watermark code in both start modes within reach, together with the exact boundary levels 0, 8..32, 96..120 and the completely full count of 128, where the transmit request must fall. Random levels are checked against threshold functions in the bench, and directed frames cover configuration freezing, start re-arming and the underrun cases.

// File: rtl/wm_ctrl_pkg.sv
package wm_ctrl_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

endpackage

// File: rtl/wm_cfg_shadow.sv
// Holds the active watermark and transmit-start threshold; loads only when enabled.
module wm_cfg_shadow #(
  parameter int DEPTH   = 128,
  parameter int WM_STEP = 8,
  parameter int CODE_W  = 2,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [CODE_W-1:0] code,
  input  logic              early,
  output logic [CNT_W-1:0]  wm_q,
  output logic [CNT_W-1:0]  start_thr_q
);

  localparam int NUM_CODES = 1 << CODE_W;

  logic [CNT_W-1:0] wm_tab   [NUM_CODES];
  logic [CNT_W-1:0] late_tab [NUM_CODES];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CODES; gi++) begin : g_tab
      assign wm_tab[gi]   = CNT_W'((gi + 1) * WM_STEP);
      assign late_tab[gi] = CNT_W'(DEPTH - (gi + 1) * WM_STEP);
    end
  endgenerate

  logic [CNT_W-1:0] wm_d;
  logic [CNT_W-1:0] start_thr_d;

  always_comb begin
    wm_d        = wm_q;
    start_thr_d = start_thr_q;
    if (cap_en) begin
      wm_d        = wm_tab[code];
      start_thr_d = early ? wm_tab[code] : late_tab[code];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm_q        <= wm_tab[0];
      start_thr_q <= late_tab[0];
    end else begin
      wm_q        <= wm_d;
      start_thr_q <= start_thr_d;
    end
  end

endmodule

// File: rtl/wm_dma_req.sv
// Burst requests for both directions, from the FIFO levels and the active watermark.
module wm_dma_req #(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] wm,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_eof_present,
  input  logic [CNT_W-1:0] tx_level,
  output logic             rx_req,
  output logic             tx_req
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] tx_free;

  always_comb begin
    tx_free = DEPTH_C - tx_level;
    rx_req  = (rx_level >= wm) | rx_eof_present;
    tx_req  = (tx_free >= wm);
  end

endmodule

// File: rtl/wm_tx_sched.sv
// Frame start sequencing and underrun detection for the transmit side.
module wm_tx_sched #(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] start_thr,
  input  logic             eof_present,
  input  logic             frame_done,
  output logic             start,
  output logic             active,
  output logic             underrun
);

  import wm_ctrl_pkg::*;

  tx_state_e state_q, state_d;
  logic      eof_seen_q, eof_seen_d;
  logic      dry_q, dry_d;
  logic      und_q, und_d;
  logic      start_ok;

  always_comb begin
    start_ok   = (tx_level >= start_thr) | eof_present;
    state_d    = state_q;
    eof_seen_d = eof_seen_q;
    start      = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (start_ok) begin
          start      = 1'b1;
          state_d    = TX_SEND;
          eof_seen_d = eof_present;
        end
      end
      TX_SEND: begin
        if (eof_present) eof_seen_d = 1'b1;
        if (frame_done) begin
          state_d    = TX_IDLE;
          eof_seen_d = 1'b0;
        end
      end
      default: state_d = TX_IDLE;
    endcase
    dry_d = (state_q == TX_SEND) && (tx_level == '0) && !eof_seen_q && !eof_present;
    und_d = dry_d && !dry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      eof_seen_q <= 1'b0;
      dry_q      <= 1'b0;
      und_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      eof_seen_q <= eof_seen_d;
      dry_q      <= dry_d;
      und_q      <= und_d;
    end
  end

  assign active   = (state_q == TX_SEND);
  assign underrun = und_q;

endmodule

// File: rtl/fifo_watermark_ctrl.sv
module fifo_watermark_ctrl #(
  parameter int DEPTH   = 128,
  parameter int WM_STEP = 8,
  parameter int CODE_W  = 2,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cfg_wm_code,
  input  logic              cfg_early_start,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic              tx_eof_present,
  input  logic              tx_frame_done,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              rx_eof_present,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              tx_start,
  output logic              tx_active,
  output logic              tx_underrun
);

  logic [CNT_W-1:0] wm_bytes;
  logic [CNT_W-1:0] start_thr;
  logic             cfg_cap_en;

  assign cfg_cap_en = !tx_active;

  wm_cfg_shadow #(
    .DEPTH(DEPTH), .WM_STEP(WM_STEP), .CODE_W(CODE_W), .CNT_W(CNT_W)
  ) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cfg_cap_en),
    .code       (cfg_wm_code),
    .early      (cfg_early_start),
    .wm_q       (wm_bytes),
    .start_thr_q(start_thr)
  );

  wm_dma_req #(
    .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) req_i (
    .wm            (wm_bytes),
    .rx_level      (rx_level),
    .rx_eof_present(rx_eof_present),
    .tx_level      (tx_level),
    .rx_req        (rx_dma_req),
    .tx_req        (tx_dma_req)
  );

  wm_tx_sched #(
    .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) sched_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_level   (tx_level),
    .start_thr  (start_thr),
    .eof_present(tx_eof_present),
    .frame_done (tx_frame_done),
    .start      (tx_start),
    .active     (tx_active),
    .underrun   (tx_underrun)
  );

endmodule

// File: rtl/wm_ctrl_checker.sv
module wm_ctrl_checker #(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_level,
  input logic             rx_eof_present,
  input logic             rx_dma_req,
  input logic             tx_dma_req,
  input logic             tx_start,
  input logic             tx_active,
  input logic             tx_underrun,
  input logic [CNT_W-1:0] wm_bytes
);

  AST_RX_EOF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eof_present |-> rx_dma_req); // R3

  AST_TX_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == CNT_W'(DEPTH)) |-> !tx_dma_req); // R4

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start); // R8

  AST_START_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_active); // R8

  AST_NO_START_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> !tx_start); // R8

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |=> !tx_underrun); // R9

  AST_UNDERRUN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underrun |-> $past(tx_active)); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> $stable(wm_bytes)); // R11

endmodule

bind fifo_watermark_ctrl wm_ctrl_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_level      (tx_level),
  .rx_eof_present(rx_eof_present),
  .rx_dma_req    (rx_dma_req),
  .tx_dma_req    (tx_dma_req),
  .tx_start      (tx_start),
  .tx_active     (tx_active),
  .tx_underrun   (tx_underrun),
  .wm_bytes      (wm_bytes)
);

// File: tb/fifo_watermark_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_watermark_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_wm_code;
  logic       cfg_early_start;
  logic [7:0] tx_level;
  logic       tx_eof_present;
  logic       tx_frame_done;
  logic [7:0] rx_level;
  logic       rx_eof_present;
  logic       rx_dma_req, tx_dma_req, tx_start, tx_active, tx_underrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fifo_watermark_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wm_code(cfg_wm_code), .cfg_early_start(cfg_early_start),
    .tx_level(tx_level), .tx_eof_present(tx_eof_present), .tx_frame_done(tx_frame_done),
    .rx_level(rx_level), .rx_eof_present(rx_eof_present),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req), .tx_start(tx_start),
    .tx_active(tx_active), .tx_underrun(tx_underrun)
  );

  function automatic int exp_wm(input logic [1:0] c);
    return (int'(c) + 1) * 8;
  endfunction

  function automatic int exp_thr(input logic [1:0] c, input logic e);
    return e ? exp_wm(c) : 128 - exp_wm(c);
  endfunction

  task automatic chk(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic apply_cfg(input logic [1:0] c, input logic e);
    cfg_wm_code = c; cfg_early_start = e;
    tx_level = 8'd0; tx_eof_present = 1'b0; tx_frame_done = 1'b1;
    tick(); tick();
    tx_frame_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0;
    cfg_wm_code = 2'b00; cfg_early_start = 1'b0;
    tx_level = 8'd0; tx_eof_present = 1'b0; tx_frame_done = 1'b0;
    rx_level = 8'd0; rx_eof_present = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset tx_active", tx_active, 1'b0);
    chk("R9 reset tx_underrun", tx_underrun, 1'b0);
    chk("R8 reset tx_start", tx_start, 1'b0);
    rst_n = 1'b1;
    tick();

    // Random levels against threshold functions: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 60; i++) begin
      logic [1:0] c;
      logic e;
      c = 2'($urandom_range(3, 0));
      e = 1'($urandom_range(1, 0));
      apply_cfg(c, e);
      rx_level       = 8'($urandom_range(128, 0));
      rx_eof_present = ($urandom_range(3, 0) == 0);
      tx_level       = 8'($urandom_range(128, 0));
      #1;
      chk("R1/R2/R3 rx_dma_req", rx_dma_req,
          (int'(rx_level) >= exp_wm(c)) || rx_eof_present);
      chk("R1/R4 tx_dma_req", tx_dma_req, (128 - int'(tx_level)) >= exp_wm(c));
      chk(e ? "R6 tx_start early" : "R5 tx_start normal", tx_start,
          int'(tx_level) >= exp_thr(c, e));
      tx_level = 8'd0;
    end

    // Exact boundaries per code: R2 R4 R5 R6
    for (int k = 0; k < 4; k++) begin
      apply_cfg(2'(k), 1'b1);
      rx_eof_present = 1'b0;
      rx_level = 8'(exp_wm(2'(k)) - 1); tx_level = 8'(exp_wm(2'(k)) - 1);
      #1;
      chk("R2 rx below watermark", rx_dma_req, 1'b0);
      chk("R6 start below early threshold", tx_start, 1'b0);
      rx_level = 8'(exp_wm(2'(k))); tx_level = 8'(exp_wm(2'(k)));
      #1;
      chk("R2 rx at watermark", rx_dma_req, 1'b1);
      chk("R6 start at early threshold", tx_start, 1'b1);
      tx_level = 8'(128 - exp_wm(2'(k)));
      #1;
      chk("R4 tx req at exact free space", tx_dma_req, 1'b1);
      tx_level = 8'(129 - exp_wm(2'(k)));
      #1;
      chk("R4 tx req one short of free space", tx_dma_req, 1'b0);
      apply_cfg(2'(k), 1'b0);
      tx_level = 8'(127 - exp_wm(2'(k)));
      #1;
      chk("R5 start below normal threshold", tx_start, 1'b0);
      tx_level = 8'(128 - exp_wm(2'(k)));
      #1;
      chk("R5 start at normal threshold", tx_start, 1'b1);
      tx_level = 8'd0;
    end

    // Full FIFO and receive end of frame: R4 R3
    apply_cfg(2'b00, 1'b1);
    tx_level = 8'd128; rx_level = 8'd0; rx_eof_present = 1'b1;
    #1;
    chk("R4 full tx fifo no request", tx_dma_req, 1'b0);
    chk("R3 rx eof with empty count", rx_dma_req, 1'b1);
    rx_eof_present = 1'b0;
    tx_level = 8'd0;

    // Frame with early start, config change mid-frame, underrun: R6 R8 R11 R9
    apply_cfg(2'b01, 1'b1);
    tx_level = 8'd20;
    #1;
    chk("R6 start with 20 bytes code 01", tx_start, 1'b1);
    tick();
    chk("R8 start pulse drops", tx_start, 1'b0);
    chk("R8 active after start", tx_active, 1'b1);
    cfg_wm_code = 2'b11; cfg_early_start = 1'b0;
    tx_level = 8'd100;
    #1;
    chk("R11 old watermark still used", tx_dma_req, 1'b1);
    tick();
    chk("R11 config held during frame", tx_dma_req, 1'b1);
    chk("R8 no second start", tx_start, 1'b0);
    tx_level = 8'd0;
    #1;
    chk("R9 underrun not yet", tx_underrun, 1'b0);
    tick();
    chk("R9 underrun pulse", tx_underrun, 1'b1);
    tick();
    chk("R9 underrun one cycle", tx_underrun, 1'b0);
    tx_frame_done = 1'b1;
    tick();
    tx_frame_done = 1'b0;
    chk("R8 idle after frame done", tx_active, 1'b0);
    tick();
    tx_level = 8'd100;
    #1;
    chk("R11 new watermark after frame", tx_dma_req, 1'b0);
    chk("R5 start at 100 with code 11", tx_start, 1'b1);
    tick();
    chk("R8 active second frame", tx_active, 1'b1);

    // End of frame seen, then drain: R10
    tx_eof_present = 1'b1;
    tick();
    tx_eof_present = 1'b0; tx_level = 8'd0;
    tick();
    chk("R10 no underrun after eof seen", tx_underrun, 1'b0);
    tick();
    chk("R10 still no underrun", tx_underrun, 1'b0);
    tx_frame_done = 1'b1;
    tick();
    tx_frame_done = 1'b0;

    // Short frame with end of frame queued: R7, and re-arm: R8
    tx_level = 8'd5; tx_eof_present = 1'b0;
    #1;
    chk("R7 no start without eof", tx_start, 1'b0);
    tx_eof_present = 1'b1;
    #1;
    chk("R7 start on eof below threshold", tx_start, 1'b1);
    tick();
    chk("R8 held condition no restart", tx_start, 1'b0);
    tx_frame_done = 1'b1;
    tick();
    tx_frame_done = 1'b0;
    #1;
    chk("R8 re-armed start", tx_start, 1'b1);
    tick();
    tx_eof_present = 1'b0; tx_level = 8'd0; tx_frame_done = 1'b1;
    tick();
    tx_frame_done = 1'b0;
    tick();

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule